// File: doc/BRIEF.md
# Masked-Write Channel Control Register

This block is the software-facing register set of a single DMA channel on a 32-bit bus. Software never writes the channel state directly. It writes a control word in which the upper half picks the bits to change and the lower half gives their new values. The block then works out whether the channel is active from the run, pause and wake bits. It also latches the address of the first descriptor and keeps three 32-bit select registers that the channel's condition logic uses.

Three one-cycle pulses go to the neighbouring logic. A flush request goes to the attached device. A kick starts the descriptor sequencer whenever a control write leaves the channel active. A fetch request, sent with the aligned pointer, loads a descriptor after the command pointer is written. The sequencer and the device themselves lie outside this block.

Top module: `chan_ctrl_regs`

## Requirements
- R1: While reset is applied and right after it, every readable register reads zero, and flush_req, kick and fetch_req are low.
- R2: A write to word offset 0x00 replaces each status bit whose mask bit (wdata[31:16]) is 1 with wdata[15:0] and keeps the others. Only RUN (bit 15), PAUSE (bit 14), FLUSH (bit 13), WAKE (bit 12) and device status (bits 7:0) can change this way. ACTIVE (bit 10), DEAD (bit 11) and bits 9:8 ignore both mask and value.
- R3: After the masked merge, these rules apply in order: WAKE=1 sets ACTIVE, RUN=1 sets ACTIVE and clears DEAD, and PAUSE=1 then clears ACTIVE.
- R4: A control write that takes RUN from 1 to 0 clears ACTIVE and DEAD.
- R5: If FLUSH is 1 after a control write, flush_req is high for exactly the one cycle after the write, and FLUSH reads back as 0.
- R6: kick is high for exactly the one cycle after a control write that leaves ACTIVE at 1, and is low after any other write.
- R7: A write to the command pointer (offset 0x0C) while ACTIVE is 1 has no effect: the pointer keeps its value and no fetch_req is issued.
- R8: An accepted command-pointer write stores the data with bits 3:0 cleared. fetch_req is then high for the one cycle after the write, with fetch_addr equal to the stored pointer.
- R9: Offset 0x00 reads zero. Offsets with no register (0x08, 0x1C and above) read zero. The status register (offset 0x04) reads with bits 31:16 at zero.
- R10: Writes to the status offset 0x04 have no effect.
- R11: The select registers at offsets 0x10, 0x14 and 0x18 store and return all 32 written bits.
- R12: A write whose address bits 1:0 are not zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| flush_req | output | 1 | One-cycle flush request to the device |
| kick | output | 1 | One-cycle start pulse to the sequencer |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| fetch_addr | output | 32 | Aligned command pointer |

## Verification
The bench steps through a chain of control words in which pause, run and wake fight over ACTIVE. A design that applied the rules in the wrong order would report the channel active while paused, or would kick a paused channel. Some words try to set ACTIVE or DEAD through the mask. A design that trusted the raw mask would let software forge channel state. The bench also writes the pointer while the channel runs and checks that it stays put. A design that accepted that write would load a new descriptor under a live sequencer. Misaligned, status-offset and unmapped accesses, together with a reset applied mid-run, are checked too. A design that missed any of these would corrupt a register or leave a bit set.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  // Status bit positions
  localparam int RUN_B    = 15;
  localparam int PAUSE_B  = 14;
  localparam int FLUSH_B  = 13;
  localparam int WAKE_B   = 12;
  localparam int DEAD_B   = 11;
  localparam int ACTIVE_B = 10;
  localparam int STAT_W   = 16;
  // Bits software may change through the control word
  localparam logic [STAT_W-1:0] CTRL_WR_MASK = 16'hF0FF;
  // Word offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CPTR = 3;
  localparam int OFS_SEL0 = 4;
  localparam int N_SEL    = 3;
  localparam int PTR_ALIGN_BITS = 4;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ccr_ctrl_update.sv
module ccr_ctrl_update
  import ccr_pkg::*;
(
  input  logic [STAT_W-1:0] old_stat,
  input  logic [31:0]       ctrl_word,
  output logic [STAT_W-1:0] new_stat,
  output logic              flush_hit
);
  logic [STAT_W-1:0] m, v, s;

  always_comb begin
    m = ctrl_word[31:16] & CTRL_WR_MASK;
    v = ctrl_word[15:0]  & CTRL_WR_MASK;
    s = (v & m) | (old_stat & ~m);
    if (s[WAKE_B]) s[ACTIVE_B] = 1'b1;
    if (s[RUN_B]) begin
      s[ACTIVE_B] = 1'b1;
      s[DEAD_B]   = 1'b0;
    end
    if (s[PAUSE_B]) s[ACTIVE_B] = 1'b0;
    if (old_stat[RUN_B] && !s[RUN_B]) begin
      s[ACTIVE_B] = 1'b0;
      s[DEAD_B]   = 1'b0;
    end
    flush_hit  = s[FLUSH_B];
    s[FLUSH_B] = 1'b0;
    new_stat   = s;
  end
endmodule

// File: rtl/ccr_cmdptr.sv
module ccr_cmdptr
  import ccr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        locked,
  input  logic [31:0] wr_data,
  output logic [31:0] ptr,
  output logic        fetch
);
  localparam logic [31:0] ALIGN_CLR = ~((32'd1 << PTR_ALIGN_BITS) - 32'd1);

  logic        take;
  logic [31:0] ptr_d;

  always_comb begin
    take  = wr_en && !locked;
    ptr_d = wr_data & ALIGN_CLR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      fetch <= 1'b0;
    end else begin
      if (take) ptr <= ptr_d;
      fetch <= take;
    end
  end
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
  import ccr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic [STAT_W-1:0]       stat,
  input  logic [31:0]             cptr,
  input  logic [N_SEL-1:0][31:0]  sel,
  output logic [31:0]             rdata
);
  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(OFS_STAT)) rdata = {{(32-STAT_W){1'b0}}, stat};
    if (idx == IDX_W'(OFS_CPTR)) rdata = cptr;
    for (int k = 0; k < N_SEL; k++) begin
      if (idx == IDX_W'(OFS_SEL0 + k)) rdata = sel[k];
    end
  end
endmodule

// File: rtl/chan_ctrl_regs.sv
module chan_ctrl_regs
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              flush_req,
  output logic              kick,
  output logic              fetch_req,
  output logic [31:0]       fetch_addr
);
  localparam int IDX_W = ADDR_W - 2;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx;
  logic              wr_ok, wr_ctrl, wr_cptr;
  logic [STAT_W-1:0] status_q, stat_d;
  logic              flush_hit;
  logic              flush_q, kick_q;
  logic [31:0]       cmdptr_q;
  logic [N_SEL-1:0][31:0] sel_q;

  ccr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    idx     = bus_addr[ADDR_W-1:2];
    wr_ok   = bus_we && (bus_addr[1:0] == 2'b00);
    wr_ctrl = wr_ok && (idx == IDX_W'(OFS_CTRL));
    wr_cptr = wr_ok && (idx == IDX_W'(OFS_CPTR));
  end

  ccr_ctrl_update u_upd (
    .old_stat (status_q),
    .ctrl_word(bus_wdata),
    .new_stat (stat_d),
    .flush_hit(flush_hit)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= '0;
      flush_q  <= 1'b0;
      kick_q   <= 1'b0;
    end else begin
      if (wr_ctrl) status_q <= stat_d;
      flush_q <= wr_ctrl && flush_hit;
      kick_q  <= wr_ctrl && stat_d[ACTIVE_B];
    end
  end

  ccr_cmdptr u_cptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_cptr),
    .locked (status_q[ACTIVE_B]),
    .wr_data(bus_wdata),
    .ptr    (cmdptr_q),
    .fetch  (fetch_req)
  );

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    logic sel_we;
    assign sel_we = wr_ok && (idx == IDX_W'(OFS_SEL0 + g));
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  sel_q[g] <= '0;
      else if (sel_we)  sel_q[g] <= bus_wdata;
    end
  end

  ccr_rdmux #(.IDX_W(IDX_W)) u_rd (
    .idx  (idx),
    .stat (status_q),
    .cptr (cmdptr_q),
    .sel  (sel_q),
    .rdata(bus_rdata)
  );

  assign flush_req  = flush_q;
  assign kick       = kick_q;
  assign fetch_addr = cmdptr_q;
endmodule

// File: rtl/ccr_chk.sv
module ccr_chk
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [STAT_W-1:0] status,
  input logic [31:0]       cmdptr,
  input logic              flush_req,
  input logic              kick,
  input logic              fetch_req
);
  localparam logic [ADDR_W-1:0] CPTR_ADDR = ADDR_W'(OFS_CPTR * 4);

  AST_PAUSE_BLOCKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    status[PAUSE_B] |-> !status[ACTIVE_B]); // R3
  AST_RUN_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[RUN_B]) |-> (!status[ACTIVE_B] && !status[DEAD_B])); // R4
  AST_FLUSH_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !status[FLUSH_B]); // R5
  AST_KICK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> status[ACTIVE_B]); // R6
  AST_CPTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CPTR_ADDR && status[ACTIVE_B]) |=> ($stable(cmdptr) && !fetch_req)); // R7
  AST_CPTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (cmdptr[PTR_ALIGN_BITS-1:0] == '0)); // R8
  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata == 32'd0)); // R9
endmodule

bind chan_ctrl_regs ccr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .status   (status_q),
  .cmdptr   (cmdptr_q),
  .flush_req(flush_req),
  .kick     (kick),
  .fetch_req(fetch_req)
);

// File: tb/chan_ctrl_regs_tb_top.sv
module chan_ctrl_regs_tb_top;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              flush_req, kick, fetch_req;
  logic [31:0]       fetch_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  chan_ctrl_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flush_req(flush_req),
    .kick(kick), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
  );

  typedef struct packed {
    logic [31:0] wd;
    logic [15:0] st;
    logic        fl;
    logic        kk;
  } vec_t;

  localparam int NV = 12;
  // control word, expected status, expected flush_req, expected kick
  localparam vec_t VECS [NV] = '{
    '{32'h8000_8000, 16'h8400, 1'b0, 1'b1},  // R3 run sets active
    '{32'h00FF_00A5, 16'h84A5, 1'b0, 1'b1},  // R2 device status
    '{32'h4000_4000, 16'hC0A5, 1'b0, 1'b0},  // R3 pause wins
    '{32'h0C00_0C00, 16'hC0A5, 1'b0, 1'b0},  // R2 active/dead not writable
    '{32'h4000_0000, 16'h84A5, 1'b0, 1'b1},  // R3 unpause
    '{32'h2000_2000, 16'h84A5, 1'b1, 1'b1},  // R5 flush
    '{32'h8000_0000, 16'h00A5, 1'b0, 1'b0},  // R4 run falls
    '{32'h1000_1000, 16'h14A5, 1'b0, 1'b1},  // R3 wake
    '{32'h5000_4000, 16'h40A5, 1'b0, 1'b0},  // R3 pause, wake off
    '{32'hD000_9000, 16'h94A5, 1'b0, 1'b1},  // R3 run+wake, no pause
    '{32'h00FF_0000, 16'h9400, 1'b0, 1'b1},  // R2 clear device status
    '{32'hF000_0000, 16'h0000, 1'b0, 1'b0}   // R4 all off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write: drive at negedge, the edge in between commits, sample pulses at next negedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(ADDR_W'(a * 4), r);
      check("R1 reset read", r, 32'd0);
    end
    check("R1 pulses", {29'd0, flush_req, kick, fetch_req}, 32'd0);

    // R8 accepted pointer write with alignment and fetch
    wr(8'h0C, 32'h0000_1237);
    check("R8 fetch_req", {31'd0, fetch_req}, 32'd1);
    check("R8 fetch_addr", fetch_addr, 32'h0000_1230);
    rd(8'h0C, r);
    check("R8 cmdptr read", r, 32'h0000_1230);
    @(negedge clk);
    check("R8 fetch one cycle", {31'd0, fetch_req}, 32'd0);

    // Vector table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(8'h00, VECS[i].wd);
      check($sformatf("R5 flush vec%0d", i), {31'd0, flush_req}, {31'd0, VECS[i].fl});
      check($sformatf("R6 kick vec%0d", i), {31'd0, kick}, {31'd0, VECS[i].kk});
      rd(8'h04, r);
      check($sformatf("R2/R3 status vec%0d", i), r, {16'd0, VECS[i].st});
      rd(8'h00, r);
      check("R9 ctrl reads zero", r, 32'd0);
    end

    // R7 pointer write ignored while active
    wr(8'h00, 32'h8000_8000);
    wr(8'h0C, 32'h0000_5550);
    check("R7 no fetch", {31'd0, fetch_req}, 32'd0);
    rd(8'h0C, r);
    check("R7 cmdptr kept", r, 32'h0000_1230);

    // R10 status write ignored
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, r);
    check("R10 status unchanged", r, 32'h0000_8400);

    // R11 select registers
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h14, 32'h1234_5678);
    wr(8'h18, 32'hA5A5_0F0F);
    rd(8'h10, r); check("R11 sel0", r, 32'hDEAD_BEEF);
    rd(8'h14, r); check("R11 sel1", r, 32'h1234_5678);
    rd(8'h18, r); check("R11 sel2", r, 32'hA5A5_0F0F);

    // R12 misaligned write ignored
    wr(8'h11, 32'h0000_0001);
    rd(8'h10, r); check("R12 misaligned", r, 32'hDEAD_BEEF);
    wr(8'h01, 32'hF000_0000);
    rd(8'h04, r); check("R12 misaligned ctrl", r, 32'h0000_8400);

    // R9 unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h08, r); check("R9 unmapped 08", r, 32'd0);
    rd(8'h1C, r); check("R9 unmapped 1C", r, 32'd0);
    rd(8'h40, r); check("R9 unmapped 40", r, 32'd0);

    // R1 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(8'h04, r); check("R1 status in reset", r, 32'd0);
    rd(8'h10, r); check("R1 sel in reset", r, 32'd0);
    rd(8'h0C, r); check("R1 cmdptr in reset", r, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pulses after reset", {29'd0, flush_req, kick, fetch_req}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule